// File: doc/BRIEF.md
# Return-Address Ring with Resident Program Counter

This block keeps the program counter of a small 8-bit processor and its subroutine return addresses in one ring of eight 14-bit registers. A 3-bit pointer picks the entry that currently serves as the program counter. A subroutine call moves the pointer forward and writes the destination into the entry it now selects. The caller's address stays where it was, in the entry just left behind. A return moves the pointer back. That makes the saved caller address live again, advanced past the call instruction. No address is ever copied from one register to another.

The sequencer drives four command strobes (advance, jump, call, return) and a target bus. The target bus is wider than the address space. The block shows the active program counter and a one-cycle flag raised when a call nests deeper than the ring can hold. Instruction decode, memory and interrupt handling sit outside this block.

Top module: `pcs_top`

## Requirements
- R1: `pc_o` is 14 bits wide. Only `tgt_i[13:0]` is used by jump and call. `tgt_i[15:14]` has no effect on any output.
- R2: While `rst` is high at a rising edge, the pointer and the selected entry are cleared. After that edge `pc_o` is 0 and `wrap_o` is 0.
- R3: An advance (`inc_i` alone) sets `pc_o` to its previous value plus one, modulo 2^14, so 0x3FFF becomes 0x0000. The pointer does not move.
- R4: A jump sets `pc_o` to `tgt_i[13:0]` on the next cycle without moving the pointer. A later return therefore lands at the same caller as it would have without the jump.
- R5: A call makes `pc_o` equal to `tgt_i[13:0]` on the next cycle. The caller's current address is kept in the entry left behind.
- R6: A return sets `pc_o` to the saved caller address plus CALL_LEN (3), modulo 2^14.
- R7: Seven nested calls followed by seven returns recover every caller in last-in first-out order.
- R8: A call made while seven return addresses are already held wraps the pointer and overwrites the oldest entry. `wrap_o` is high for exactly the one cycle after that call. A following return resumes the seventh caller.
- R9: When several strobes are high together, call wins over return, return over jump, and jump over advance.
- R10: `wrap_o` stays low after any command other than an overflowing call. With no strobe high, `pc_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| inc_i | input | 1 | Advance the program counter by one |
| jump_i | input | 1 | Load the target into the program counter |
| call_i | input | 1 | Push: move the pointer forward and load the target |
| ret_i | input | 1 | Pop: move the pointer back and skip past the call |
| tgt_i | input | 16 | Target address; upper two bits ignored |
| pc_o | output | 14 | Active program counter |
| wrap_o | output | 1 | One-cycle pulse on a call that overflows the ring |

## Verification
The embedded assertions check, on every cycle, how the pointer moves for each winning command. They also check the next program counter after advance, jump and call, and that `wrap_o` only follows a call. Several things depend on long command histories, so only the bench scenarios show them. These are last-in first-out recovery across seven levels, the overwrite of the oldest entry on the eighth call, a return landing correctly after an intervening jump, and the priority among simultaneous strobes. A random mix of commands is compared against a ring model kept in the bench.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

    localparam int ADDR_W   = 14;
    localparam int DEPTH    = 8;
    localparam int PTR_W    = $clog2(DEPTH);
    localparam int TGT_W    = 16;
    localparam int CALL_LEN = 3;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [PTR_W-1:0]  ptr_t;

    typedef enum logic [2:0] {
        OP_IDLE = 3'd0,
        OP_INC  = 3'd1,
        OP_JUMP = 3'd2,
        OP_RET  = 3'd3,
        OP_CALL = 3'd4
    } op_e;

    typedef struct packed {
        op_e   op;
        addr_t tgt;
    } req_t;

    function automatic addr_t addr_add(addr_t a, int unsigned b);
        addr_t bb;
        bb = addr_t'(b);
        return a + bb;
    endfunction

    function automatic ptr_t ptr_fwd(ptr_t p);
        return p + ptr_t'(1);
    endfunction

    function automatic ptr_t ptr_back(ptr_t p);
        return p - ptr_t'(1);
    endfunction

endpackage

// File: rtl/pcs_cmd_decode.sv
module pcs_cmd_decode
    import pcs_pkg::*;
#(
    parameter int TW = TGT_W
) (
    input  logic          inc_i,
    input  logic          jump_i,
    input  logic          call_i,
    input  logic          ret_i,
    input  logic [TW-1:0] tgt_i,
    output req_t          req_o
);
    localparam int DROP_W = TW - ADDR_W;

    logic [DROP_W-1:0] unused_hi;

    always_comb begin
        req_o.tgt = tgt_i[ADDR_W-1:0];
        unused_hi = tgt_i[TW-1:ADDR_W];
        if (call_i)      req_o.op = OP_CALL;
        else if (ret_i)  req_o.op = OP_RET;
        else if (jump_i) req_o.op = OP_JUMP;
        else if (inc_i)  req_o.op = OP_INC;
        else             req_o.op = OP_IDLE;
    end

    logic unused_ok;
    assign unused_ok = ^unused_hi;

endmodule

// File: rtl/pcs_ptr_ctrl.sv
module pcs_ptr_ctrl
    import pcs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  op_e  op_i,
    output ptr_t ptr_o,
    output ptr_t ptr_nxt_o,
    output logic wrap_o
);
    localparam ptr_t FULL = ptr_t'(DEPTH - 1);

    ptr_t ptr_q, depth_q, depth_d;
    logic wrap_q, wrap_d;

    always_comb begin
        ptr_nxt_o = ptr_q;
        depth_d   = depth_q;
        wrap_d    = 1'b0;
        unique case (op_i)
            OP_CALL: begin
                ptr_nxt_o = ptr_fwd(ptr_q);
                if (depth_q == FULL) wrap_d = 1'b1;
                else                 depth_d = depth_q + ptr_t'(1);
            end
            OP_RET: begin
                ptr_nxt_o = ptr_back(ptr_q);
                if (depth_q != '0) depth_d = depth_q - ptr_t'(1);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q   <= '0;
            depth_q <= '0;
            wrap_q  <= 1'b0;
        end else begin
            ptr_q   <= ptr_nxt_o;
            depth_q <= depth_d;
            wrap_q  <= wrap_d;
        end
    end

    assign ptr_o  = ptr_q;
    assign wrap_o = wrap_q;

    AST_PTR_FWD_ON_CALL: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_CALL) |=> (ptr_q == $past(ptr_q) + ptr_t'(1))); // R5
    AST_PTR_BACK_ON_RET: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_RET) |=> (ptr_q == $past(ptr_q) - ptr_t'(1))); // R6
    AST_PTR_STILL_ON_JUMP: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_JUMP || op_i == OP_INC || op_i == OP_IDLE) |=> $stable(ptr_q)); // R4
    AST_WRAP_ONLY_AFTER_CALL: assert property (@(posedge clk) disable iff (rst)
        (op_i != OP_CALL) |=> !wrap_q); // R10

endmodule

// File: rtl/pcs_entry_file.sv
module pcs_entry_file
    import pcs_pkg::*;
#(
    parameter int N = DEPTH
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  we_i,
    input  ptr_t  waddr_i,
    input  addr_t wdata_i,
    input  ptr_t  cur_i,
    output addr_t cur_o,
    output addr_t prev_o
);
    addr_t ent [N];

    for (genvar g = 0; g < N; g++) begin : g_ent
        if (g == 0) begin : g_rst
            always_ff @(posedge clk) begin
                if (rst)                                 ent[g] <= '0;
                else if (we_i && waddr_i == ptr_t'(g))   ent[g] <= wdata_i;
            end
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (we_i && waddr_i == ptr_t'(g)) ent[g] <= wdata_i;
            end
        end
    end

    assign cur_o  = ent[cur_i];
    assign prev_o = ent[ptr_back(cur_i)];

endmodule

// File: rtl/pcs_top.sv
module pcs_top
    import pcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              inc_i,
    input  logic              jump_i,
    input  logic              call_i,
    input  logic              ret_i,
    input  logic [TGT_W-1:0]  tgt_i,
    output logic [ADDR_W-1:0] pc_o,
    output logic              wrap_o
);
    req_t  req;
    ptr_t  ptr, ptr_nxt;
    addr_t cur, prev, wdata;
    logic  we;

    pcs_cmd_decode #(.TW(TGT_W)) u_dec (
        .inc_i (inc_i),
        .jump_i(jump_i),
        .call_i(call_i),
        .ret_i (ret_i),
        .tgt_i (tgt_i),
        .req_o (req)
    );

    pcs_ptr_ctrl u_ptr (
        .clk      (clk),
        .rst      (rst),
        .op_i     (req.op),
        .ptr_o    (ptr),
        .ptr_nxt_o(ptr_nxt),
        .wrap_o   (wrap_o)
    );

    always_comb begin
        we    = 1'b1;
        wdata = cur;
        unique case (req.op)
            OP_CALL: wdata = req.tgt;
            OP_JUMP: wdata = req.tgt;
            OP_RET:  wdata = addr_add(prev, CALL_LEN);
            OP_INC:  wdata = addr_add(cur, 1);
            default: we = 1'b0;
        endcase
    end

    pcs_entry_file #(.N(DEPTH)) u_file (
        .clk    (clk),
        .rst    (rst),
        .we_i   (we),
        .waddr_i(ptr_nxt),
        .wdata_i(wdata),
        .cur_i  (ptr),
        .cur_o  (cur),
        .prev_o (prev)
    );

    assign pc_o = cur;

    AST_INC_ADDS_ONE: assert property (@(posedge clk) disable iff (rst)
        (inc_i && !jump_i && !call_i && !ret_i) |=> (pc_o == $past(pc_o) + 14'd1)); // R3
    AST_JUMP_LOADS: assert property (@(posedge clk) disable iff (rst)
        (jump_i && !call_i && !ret_i) |=> (pc_o == $past(tgt_i[13:0]))); // R4
    AST_CALL_LOADS: assert property (@(posedge clk) disable iff (rst)
        call_i |=> (pc_o == $past(tgt_i[13:0]))); // R5
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!inc_i && !jump_i && !call_i && !ret_i) |=> $stable(pc_o)); // R10

endmodule

// File: tb/pcs_top_tb.sv
module pcs_top_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        inc_i, jump_i, call_i, ret_i;
    logic [15:0] tgt_i;
    logic [13:0] pc_o;
    logic        wrap_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [13:0] m_ent [8];
    int m_ptr, m_depth;
    bit m_wrap;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcs_top u_dut (
        .clk(clk), .rst(rst), .inc_i(inc_i), .jump_i(jump_i),
        .call_i(call_i), .ret_i(ret_i), .tgt_i(tgt_i),
        .pc_o(pc_o), .wrap_o(wrap_o)
    );

    function automatic logic [13:0] exp_pc();
        return m_ent[m_ptr];
    endfunction

    // Reference ring from the requirements: call > ret > jump > inc.
    task automatic model(input bit i, input bit j, input bit c, input bit r, input logic [15:0] t);
        m_wrap = 0;
        if (c) begin
            if (m_depth == 7) m_wrap = 1; else m_depth++;
            m_ptr = (m_ptr + 1) % 8;
            m_ent[m_ptr] = t[13:0];
        end else if (r) begin
            int p;
            p = (m_ptr + 7) % 8;
            if (m_depth > 0) m_depth--;
            m_ent[p] = m_ent[p] + 14'd3;
            m_ptr = p;
        end else if (j) begin
            m_ent[m_ptr] = t[13:0];
        end else if (i) begin
            m_ent[m_ptr] = m_ent[m_ptr] + 14'd1;
        end
    endtask

    task automatic chk(input string req, input logic [13:0] act, input logic [13:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input string req, input bit i, input bit j, input bit c, input bit r,
                        input logic [15:0] t);
        inc_i = i; jump_i = j; call_i = c; ret_i = r; tgt_i = t;
        model(i, j, c, r, t);
        @(posedge clk);
        @(negedge clk);
        chk(req, pc_o, exp_pc());
        chk({req, " wrap"}, {13'd0, wrap_o}, {13'd0, m_wrap});
        inc_i = 0; jump_i = 0; call_i = 0; ret_i = 0;
    endtask

    task automatic do_reset();
        rst = 1; inc_i = 0; jump_i = 0; call_i = 0; ret_i = 0; tgt_i = 16'hFFFF;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 0;
        m_ptr = 0; m_depth = 0; m_wrap = 0; m_ent[0] = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog expired actual=%h expected=%h", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd8008));
        do_reset();
        // R2 reset state
        chk("R2 pc", pc_o, 14'd0);
        chk("R2 wrap", {13'd0, wrap_o}, 14'd0);

        // R3 increment and wrap at top of space
        step("R3 inc", 1, 0, 0, 0, 16'h0);
        step("R1 jump upper bits ignored", 0, 1, 0, 0, 16'hFFFE);
        chk("R1 pc", pc_o, 14'h3FFE);
        step("R3 inc", 1, 0, 0, 0, 16'h0);
        step("R3 wrap", 1, 0, 0, 0, 16'h0);
        chk("R3 wrapped", pc_o, 14'h0000);

        // R5/R6 call and return, R4 jump inside a subroutine
        step("R4 jump", 0, 1, 0, 0, 16'h0100);
        step("R5 call", 0, 0, 1, 0, 16'hC200);
        chk("R5 target", pc_o, 14'h0200);
        step("R4 jump in sub", 0, 1, 0, 0, 16'h0300);
        step("R6 ret", 0, 0, 0, 1, 16'h0);
        chk("R6 caller+3", pc_o, 14'h0103);

        // R7 seven-deep nesting
        for (int k = 1; k <= 7; k++) step("R7 call", 0, 0, 1, 0, 16'(k * 16'h0111));
        for (int k = 7; k >= 1; k--) step("R7 ret", 0, 0, 0, 1, 16'h0);
        chk("R7 back at base", pc_o, 14'h0106);

        // R8 eighth call overflows
        for (int k = 1; k <= 7; k++) step("R8 fill", 0, 0, 1, 0, 16'(k * 16'h0020));
        step("R8 overflow call", 0, 0, 1, 0, 16'h2000);
        chk("R8 wrap pulse", {13'd0, wrap_o}, 14'd1);
        step("R8 pulse ends", 1, 0, 0, 0, 16'h0);
        chk("R8 wrap low", {13'd0, wrap_o}, 14'd0);
        step("R8 ret to 7th caller", 0, 0, 0, 1, 16'h0);
        chk("R8 seventh caller", pc_o, 14'h00E3);

        // R9 priority
        do_reset();
        step("R9 call beats all", 1, 1, 1, 1, 16'h0055);
        step("R9 ret beats jump", 1, 1, 0, 1, 16'h0777);
        chk("R9 ret result", pc_o, 14'h0003);
        step("R9 jump beats inc", 1, 1, 0, 0, 16'h0444);
        chk("R9 jump result", pc_o, 14'h0444);

        // R10 idle holds
        step("R10 idle", 0, 0, 0, 0, 16'h1234);
        chk("R10 hold", pc_o, 14'h0444);

        // Random mix (R3, R4, R5, R6, R9)
        for (int n = 0; n < 3000; n++) begin
            bit i, j, c, r;
            logic [15:0] t;
            i = 1'($urandom); j = 1'($urandom); c = ($urandom % 5) == 0;
            r = ($urandom % 4) == 0;
            if (m_depth == 0) r = 0;
            if (c && m_depth == 7) c = ($urandom % 2) == 0;
            t = 16'($urandom);
            step("R9 random mix", i, j, c, r, t);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule